// File: doc/BRIEF.md
# I2C Slave Receive Engine with Host-Decided Acknowledge

This block is the receive half of an I2C target for 7-bit addressing. It runs on a fast system clock and oversamples the bus lines SCL and SDA. It finds start and stop conditions and shifts in the address byte, then the data bytes that follow it. The top seven bits of the address byte are compared with a 7-bit own-address input. The block answers each byte by pulling SDA low to acknowledge it, or by leaving SDA released to refuse it. It holds SCL low whenever the host must act before the bus can continue.

The host side looks like a small register file driven by plain wires. The host sees a receive buffer, a buffer-full flag, an overflow flag, a sticky interrupt flag and a clock-release bit. It also sees an acknowledge-time bit, start and stop status bits and the read/write bit of the last address. Single-cycle strobes read the buffer, clear the interrupt, clear the overflow and release the clock. Level inputs enable each of the following:
- holding after an address byte;
- holding after a data byte;
- stretching after each acknowledge;
- accepting bytes while the buffer is full;
- interrupts on start and on stop.

In the hold modes the host chooses ACK or NACK itself through a level input, before the ninth clock.

Top module: `i2c_rx_hold`

## Requirements
- R1: An address byte whose upper seven bits equal `own_addr` and whose LSB is 0 is placed in `rx_data` (as `{own_addr,1'b0}`). It sets `buf_full`, drives SDA low during the ninth clock, and leaves `rw_bit` at 0.
- R2: An address byte whose upper seven bits differ from `own_addr` gets no acknowledge. It leaves `rx_data`, `buf_full` and `irq` unchanged, and all bytes up to the next start are ignored.
- R3: `irq` goes to 1 after the ninth falling SCL edge of every acknowledged byte, with or without stretching. It stays at 1 until `flag_clr` is pulsed. It is not set by the ninth edge of a byte answered with NACK.
- R4: When `buf_full` or `ovf` is 1 as a byte completes and `override_en` is 0, the byte is refused with NACK. `ovf` goes to 1 and `rx_data` keeps its old value. `ovf` clears only on `ovf_clr`.
- R5: With `override_en` at 1, a byte completing while `buf_full` or `ovf` is 1 is still loaded into `rx_data` and acknowledged.
- R6: A `buf_rd` pulse clears `buf_full`.
- R7: With `stretch_en` at 1, after the ninth falling edge of each acknowledged byte, `rel` drops to 0 and `scl_oe` holds SCL low. This lasts until a `rel_wr` pulse, after which SCL is released.
- R8: With `addr_hold_en` (for a matching write address) or `data_hold_en` (for a data byte), the eighth falling SCL edge loads the byte, sets `irq`, clears `rel` and holds SCL low with SDA released. At the next `rel_wr`, the `ack_nack` level is used: 0 means ACK and 1 means NACK.
- R9: `ack_time` is 1 from the eighth falling edge of a loaded byte until its ninth falling edge, and 0 otherwise.
- R10: A start sets `start_seen` and clears `stop_seen`; a stop does the reverse. Each of them sets `irq` only when `start_irq_en` or `stop_irq_en` respectively is 1.
- R11: An address byte matching `own_addr` with LSB 1 sets `rw_bit` to 1. It gets no acknowledge and does not load the buffer.
- R12: Both lines are open-drain: `scl_oe`/`sda_oe` at 1 pull the line low. `sda_oe` changes only while the synchronized SCL is low.
- R13: After a NACK (refused, overflowed or host-chosen), further bytes are ignored until the next start condition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| own_addr | input | 7 | Own 7-bit bus address |
| addr_hold_en | input | 1 | Hold for a host decision after a matching address byte |
| data_hold_en | input | 1 | Hold for a host decision after each data byte |
| stretch_en | input | 1 | Stretch SCL after every acknowledged byte |
| override_en | input | 1 | Accept bytes even when buffer full or overflowed |
| start_irq_en | input | 1 | Interrupt on start condition |
| stop_irq_en | input | 1 | Interrupt on stop condition |
| ack_nack | input | 1 | Host answer in hold modes: 0 ACK, 1 NACK |
| buf_rd | input | 1 | Strobe: host reads the buffer |
| flag_clr | input | 1 | Strobe: clear interrupt flag |
| ovf_clr | input | 1 | Strobe: clear overflow flag |
| rel_wr | input | 1 | Strobe: release the held clock |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_oe | output | 1 | Pull SCL low |
| sda_oe | output | 1 | Pull SDA low |
| rx_data | output | 8 | Receive buffer |
| buf_full | output | 1 | Buffer holds an unread byte |
| ovf | output | 1 | Overflow flag |
| irq | output | 1 | Sticky interrupt flag |
| rel | output | 1 | Clock-release bit (0 while the engine may hold SCL) |
| ack_time | output | 1 | Pending event is before the acknowledge slot |
| rw_bit | output | 1 | R/W bit of the last matching address |
| start_seen | output | 1 | Start condition seen last |
| stop_seen | output | 1 | Stop condition seen last |

## Verification
The bench builds the block with its default two-stage synchronizer and own address 7'h3A. It drives the bus from a bit-banged master whose quarter period is ten system clocks. That is well beyond the four-cycle latency from a line edge to a state change, so every decision the engine takes at the eighth or ninth falling edge can be seen while SCL is still low. The master waits for SCL to read high before it continues, so stretching and the hold modes really stall the bus. The bench shows each stall by watching `scl_oe` and the wired line level before and after `rel_wr`. Pairs of bytes sent without a read in between bring the full-buffer refusal, the override path and the end of the transaction after a NACK within reach.

// File: rtl/i2c_rx_pkg.sv
package i2c_rx_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 7;
  localparam int CNT_W  = $clog2(BYTE_W + 1);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_DATA,
    ST_HOLD8,
    ST_ACKSET,
    ST_ACK,
    ST_HOLD9
  } rx_state_e;
endpackage

// File: rtl/i2c_rx_sync.sv
module i2c_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_q, sda_q, scl_n, sda_n;
  logic              scl_p, sda_p;

  assign scl_n[0] = scl_i;
  assign sda_n[0] = sda_i;
  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    assign scl_n[g] = scl_q[g-1];
    assign sda_n[g] = sda_q[g-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= '1;
      sda_q <= '1;
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_q <= scl_n;
      sda_q <= sda_n;
      scl_p <= scl_q[STAGES-1];
      sda_p <= sda_q[STAGES-1];
    end
  end

  assign scl_s     = scl_q[STAGES-1];
  assign sda_s     = sda_q[STAGES-1];
  assign scl_rise  = scl_s & ~scl_p;
  assign scl_fall  = ~scl_s & scl_p;
  assign start_det = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_det  = scl_s & scl_p & ~sda_p & sda_s;
endmodule

// File: rtl/i2c_rx_ctrl.sv
module i2c_rx_ctrl
  import i2c_rx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic              scl_s,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic              addr_hold_en,
  input  logic              data_hold_en,
  input  logic              stretch_en,
  input  logic              override_en,
  input  logic              buf_full,
  input  logic              ovf,
  input  logic              rel_wr,
  input  logic              ack_nack,
  output logic              scl_oe,
  output logic              sda_oe,
  output logic              load_en,
  output logic [BYTE_W-1:0] load_byte,
  output logic              set_irq,
  output logic              set_ovf,
  output logic              clr_rel,
  output logic              ack8,
  output logic              ack9,
  output logic              rw_upd,
  output logic              rw_val
);
  rx_state_e         state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [BYTE_W-1:0] sh_q, sh_d;
  logic              sda_q, sda_d;
  logic              acked_q, acked_d;
  logic              byte_end, is_addr, hit, blocked, hold_req;

  assign byte_end  = scl_fall && (cnt_q == CNT_W'(BYTE_W));
  assign is_addr   = (state_q == ST_ADDR);
  assign hit       = (sh_q[BYTE_W-1:1] == own_addr);
  assign blocked   = (buf_full | ovf) & ~override_en;
  assign hold_req  = is_addr ? addr_hold_en : data_hold_en;
  assign load_byte = sh_q;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    sh_d    = sh_q;
    sda_d   = sda_q;
    acked_d = acked_q;
    load_en = 1'b0;
    set_irq = 1'b0;
    set_ovf = 1'b0;
    clr_rel = 1'b0;
    ack8    = 1'b0;
    ack9    = 1'b0;
    rw_upd  = 1'b0;
    rw_val  = 1'b0;
    unique case (state_q)
      ST_ADDR, ST_DATA: begin
        if (scl_rise) begin
          sh_d  = {sh_q[BYTE_W-2:0], sda_s};
          cnt_d = cnt_q + 1'b1;
        end else if (byte_end) begin
          if (is_addr && hit) begin
            rw_upd = 1'b1;
            rw_val = sh_q[0];
          end
          if (is_addr && !(hit && !sh_q[0])) begin
            state_d = ST_IDLE;
          end else if (blocked) begin
            set_ovf = 1'b1;
            acked_d = 1'b0;
            sda_d   = 1'b0;
            state_d = ST_ACK;
          end else begin
            load_en = 1'b1;
            ack8    = 1'b1;
            if (hold_req) begin
              set_irq = 1'b1;
              clr_rel = 1'b1;
              state_d = ST_HOLD8;
            end else begin
              acked_d = 1'b1;
              sda_d   = 1'b1;
              state_d = ST_ACK;
            end
          end
        end
      end
      ST_HOLD8: begin
        if (rel_wr) begin
          acked_d = ~ack_nack;
          sda_d   = ~ack_nack;
          state_d = ST_ACKSET;
        end
      end
      ST_ACKSET: state_d = ST_ACK;
      ST_ACK: begin
        if (scl_fall) begin
          sda_d = 1'b0;
          ack9  = 1'b1;
          cnt_d = '0;
          if (acked_q) begin
            set_irq = 1'b1;
            if (stretch_en) begin
              clr_rel = 1'b1;
              state_d = ST_HOLD9;
            end else begin
              state_d = ST_DATA;
            end
          end else begin
            state_d = ST_IDLE;
          end
        end
      end
      ST_HOLD9: if (rel_wr) state_d = ST_DATA;
      default: ;
    endcase
    if (start_det) begin
      state_d = ST_ADDR;
      cnt_d   = '0;
      sda_d   = 1'b0;
    end else if (stop_det) begin
      state_d = ST_IDLE;
      sda_d   = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      sh_q    <= '0;
      sda_q   <= 1'b0;
      acked_q <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      sh_q    <= sh_d;
      sda_q   <= sda_d;
      acked_q <= acked_d;
    end
  end

  assign sda_oe = sda_q;
  assign scl_oe = (state_q == ST_HOLD8) || (state_q == ST_ACKSET) || (state_q == ST_HOLD9);

  // R12: SDA is only ever moved while the sampled clock is low
  a_r12_sda_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe != $past(sda_oe)) |-> !$past(scl_s));

  // R13: after a refused or ignored byte nothing is driven on SDA
  a_r13_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE) |-> (!sda_oe && !scl_oe));
endmodule

// File: rtl/i2c_rx_regs.sv
module i2c_rx_regs
  import i2c_rx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en,
  input  logic [BYTE_W-1:0] load_byte,
  input  logic              set_irq,
  input  logic              set_ovf,
  input  logic              clr_rel,
  input  logic              ack8,
  input  logic              ack9,
  input  logic              rw_upd,
  input  logic              rw_val,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic              start_irq_en,
  input  logic              stop_irq_en,
  input  logic              buf_rd,
  input  logic              flag_clr,
  input  logic              ovf_clr,
  input  logic              rel_wr,
  output logic [BYTE_W-1:0] rx_data,
  output logic              buf_full,
  output logic              ovf,
  output logic              irq,
  output logic              rel,
  output logic              ack_time,
  output logic              rw_bit,
  output logic              start_seen,
  output logic              stop_seen
);
  logic [BYTE_W-1:0] data_q;
  logic full_q, full_d, ovf_q, ovf_d, irq_q, irq_d, rel_q, rel_d;
  logic at_q, at_d, rw_q, st_q, st_d, sp_q, sp_d, irq_evt;

  assign irq_evt = set_irq | (start_det & start_irq_en) | (stop_det & stop_irq_en);

  always_comb begin
    irq_d  = irq_q;
    full_d = full_q;
    ovf_d  = ovf_q;
    rel_d  = rel_q;
    at_d   = at_q;
    st_d   = st_q;
    sp_d   = sp_q;
    if (flag_clr) irq_d = 1'b0;
    if (irq_evt)  irq_d = 1'b1;
    if (buf_rd)   full_d = 1'b0;
    if (load_en)  full_d = 1'b1;
    if (ovf_clr)  ovf_d = 1'b0;
    if (set_ovf)  ovf_d = 1'b1;
    if (rel_wr)   rel_d = 1'b1;
    if (clr_rel)  rel_d = 1'b0;
    if (ack9 | start_det | stop_det) at_d = 1'b0;
    if (ack8)     at_d = 1'b1;
    if (start_det) begin
      st_d = 1'b1;
      sp_d = 1'b0;
    end else if (stop_det) begin
      st_d = 1'b0;
      sp_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      rw_q   <= 1'b0;
    end else begin
      if (load_en) data_q <= load_byte;
      if (rw_upd)  rw_q   <= rw_val;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      ovf_q  <= 1'b0;
      irq_q  <= 1'b0;
      rel_q  <= 1'b1;
      at_q   <= 1'b0;
      st_q   <= 1'b0;
      sp_q   <= 1'b0;
    end else begin
      full_q <= full_d;
      ovf_q  <= ovf_d;
      irq_q  <= irq_d;
      rel_q  <= rel_d;
      at_q   <= at_d;
      st_q   <= st_d;
      sp_q   <= sp_d;
    end
  end

  assign rx_data    = data_q;
  assign buf_full   = full_q;
  assign ovf        = ovf_q;
  assign irq        = irq_q;
  assign rel        = rel_q;
  assign ack_time   = at_q;
  assign rw_bit     = rw_q;
  assign start_seen = st_q;
  assign stop_seen  = sp_q;

  // R3: interrupt flag is sticky until the host clears it
  a_r3_irq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !flag_clr) |=> irq);

  // R6: a host read empties the buffer unless a new byte lands
  a_r6_read_clears_full: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_rd && !load_en) |=> !buf_full);

  // R10: a stop leaves only the stop status bit set
  a_r10_stop_status: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_det && !start_det) |=> (stop_seen && !start_seen));
endmodule

// File: rtl/i2c_rx_hold.sv
module i2c_rx_hold
  import i2c_rx_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic              addr_hold_en,
  input  logic              data_hold_en,
  input  logic              stretch_en,
  input  logic              override_en,
  input  logic              start_irq_en,
  input  logic              stop_irq_en,
  input  logic              ack_nack,
  input  logic              buf_rd,
  input  logic              flag_clr,
  input  logic              ovf_clr,
  input  logic              rel_wr,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              scl_oe,
  output logic              sda_oe,
  output logic [BYTE_W-1:0] rx_data,
  output logic              buf_full,
  output logic              ovf,
  output logic              irq,
  output logic              rel,
  output logic              ack_time,
  output logic              rw_bit,
  output logic              start_seen,
  output logic              stop_seen
);
  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic load_en, set_irq, set_ovf, clr_rel, ack8, ack9, rw_upd, rw_val;
  logic [BYTE_W-1:0] load_byte;

  i2c_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  i2c_rx_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .own_addr(own_addr),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det),
    .addr_hold_en(addr_hold_en), .data_hold_en(data_hold_en),
    .stretch_en(stretch_en), .override_en(override_en),
    .buf_full(buf_full), .ovf(ovf), .rel_wr(rel_wr), .ack_nack(ack_nack),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .load_en(load_en), .load_byte(load_byte),
    .set_irq(set_irq), .set_ovf(set_ovf), .clr_rel(clr_rel),
    .ack8(ack8), .ack9(ack9), .rw_upd(rw_upd), .rw_val(rw_val)
  );

  i2c_rx_regs u_regs (
    .clk(clk), .rst_n(rst_n), .load_en(load_en), .load_byte(load_byte),
    .set_irq(set_irq), .set_ovf(set_ovf), .clr_rel(clr_rel),
    .ack8(ack8), .ack9(ack9), .rw_upd(rw_upd), .rw_val(rw_val),
    .start_det(start_det), .stop_det(stop_det),
    .start_irq_en(start_irq_en), .stop_irq_en(stop_irq_en),
    .buf_rd(buf_rd), .flag_clr(flag_clr), .ovf_clr(ovf_clr), .rel_wr(rel_wr),
    .rx_data(rx_data), .buf_full(buf_full), .ovf(ovf), .irq(irq), .rel(rel),
    .ack_time(ack_time), .rw_bit(rw_bit),
    .start_seen(start_seen), .stop_seen(stop_seen)
  );

  // R4: a refused byte raises overflow and leaves SDA released
  a_r4_blocked_nack: assert property (@(posedge clk) disable iff (!rst_n)
    set_ovf |=> (ovf && !sda_oe));

  // R7 / R8: the clock is only grabbed with the release bit cleared
  a_r7_hold_needs_release: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scl_oe) |-> !rel);
endmodule

// File: tb/i2c_rx_hold_test.sv
module i2c_rx_hold_test;
  localparam int Q = 10;
  localparam logic [6:0] OWN = 7'h3A;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic addr_hold_en = 0, data_hold_en = 0, stretch_en = 0, override_en = 0;
  logic start_irq_en = 0, stop_irq_en = 0, ack_nack = 0;
  logic buf_rd = 0, flag_clr = 0, ovf_clr = 0, rel_wr = 0;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic scl_oe, sda_oe, buf_full, ovf, irq, rel, ack_time, rw_bit, start_seen, stop_seen;
  logic [7:0] rx_data;
  logic scl_bus, sda_bus, ak;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  assign scl_bus = m_scl & ~scl_oe;
  assign sda_bus = m_sda & ~sda_oe;

  i2c_rx_hold uut (
    .clk(clk), .rst_n(rst_n), .own_addr(OWN),
    .addr_hold_en(addr_hold_en), .data_hold_en(data_hold_en),
    .stretch_en(stretch_en), .override_en(override_en),
    .start_irq_en(start_irq_en), .stop_irq_en(stop_irq_en), .ack_nack(ack_nack),
    .buf_rd(buf_rd), .flag_clr(flag_clr), .ovf_clr(ovf_clr), .rel_wr(rel_wr),
    .scl_i(scl_bus), .sda_i(sda_bus), .scl_oe(scl_oe), .sda_oe(sda_oe),
    .rx_data(rx_data), .buf_full(buf_full), .ovf(ovf), .irq(irq), .rel(rel),
    .ack_time(ack_time), .rw_bit(rw_bit), .start_seen(start_seen), .stop_seen(stop_seen)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_high();
    while (!scl_bus) tick(1);
  endtask

  task automatic m_start();
    m_sda = 1'b1; m_scl = 1'b1; tick(Q);
    m_sda = 1'b0; tick(Q);
    m_scl = 1'b0; tick(Q);
  endtask

  task automatic m_stop();
    m_sda = 1'b0; tick(Q);
    m_scl = 1'b1; wait_high(); tick(Q);
    m_sda = 1'b1; tick(Q);
  endtask

  task automatic m_bits8(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; tick(Q);
      m_scl = 1'b1; wait_high(); tick(2*Q);
      m_scl = 1'b0; tick(Q);
    end
  endtask

  task automatic m_ack(output logic a);
    m_sda = 1'b1; tick(Q);
    m_scl = 1'b1; wait_high(); tick(Q);
    a = ~sda_bus; tick(Q);
    m_scl = 1'b0; tick(Q);
  endtask

  task automatic pulse_rd();  buf_rd = 1;   tick(1); buf_rd = 0;   tick(1); endtask
  task automatic pulse_clr(); flag_clr = 1; tick(1); flag_clr = 0; tick(1); endtask
  task automatic pulse_rel(); rel_wr = 1;   tick(1); rel_wr = 0;   tick(2); endtask
  task automatic pulse_ovc(); ovf_clr = 1;  tick(1); ovf_clr = 0;  tick(1); endtask

  task automatic t_reset();
    check("R12 reset scl_oe", scl_oe, 0);
    check("R12 reset sda_oe", sda_oe, 0);
    check("R3 reset irq", irq, 0);
    check("R6 reset buf_full", buf_full, 0);
    check("R4 reset ovf", ovf, 0);
    check("R7 reset rel", rel, 1);
    check("R10 reset start", start_seen, 0);
  endtask

  task automatic t_write();
    m_start();
    check("R10 start_seen", start_seen, 1);
    check("R10 no start irq", irq, 0);
    m_bits8({OWN, 1'b0});
    check("R9 ack_time at 8th", ack_time, 1);
    m_ack(ak);
    check("R1 addr ACK", ak, 1);
    check("R1 rx_data addr", rx_data, {OWN, 1'b0});
    check("R1 rw_bit", rw_bit, 0);
    check("R1 buf_full", buf_full, 1);
    check("R9 ack_time after 9th", ack_time, 0);
    check("R3 irq after addr", irq, 1);
    tick(20);
    check("R3 irq sticky", irq, 1);
    pulse_clr();
    check("R3 irq cleared", irq, 0);
    pulse_rd();
    check("R6 read clears full", buf_full, 0);
    m_bits8(8'hA5);
    m_ack(ak);
    check("R3 data ACK", ak, 1);
    check("R3 rx_data data", rx_data, 8'hA5);
    check("R3 irq after data", irq, 1);
    pulse_clr(); pulse_rd();
    m_stop();
    check("R10 stop_seen", stop_seen, 1);
    check("R10 start cleared", start_seen, 0);
    check("R10 no stop irq", irq, 0);
  endtask

  task automatic t_mismatch();
    m_start();
    m_bits8(8'h40);
    m_ack(ak);
    check("R2 mismatch NACK", ak, 0);
    check("R2 full untouched", buf_full, 0);
    check("R2 no irq", irq, 0);
    m_bits8({OWN, 1'b0});
    m_ack(ak);
    check("R2 ignored until start", ak, 0);
    check("R2 rx_data kept", rx_data, 8'hA5);
    m_stop();
  endtask

  task automatic t_read();
    m_start();
    m_bits8({OWN, 1'b1});
    m_ack(ak);
    check("R11 read NACK", ak, 0);
    check("R11 rw_bit set", rw_bit, 1);
    check("R11 no load", buf_full, 0);
    m_stop();
  endtask

  task automatic t_overflow();
    m_start();
    m_bits8({OWN, 1'b0}); m_ack(ak);
    pulse_rd();
    m_bits8(8'h11); m_ack(ak);
    check("R4 first data ACK", ak, 1);
    m_bits8(8'h22); m_ack(ak);
    check("R4 full NACK", ak, 0);
    check("R4 ovf set", ovf, 1);
    check("R4 rx_data kept", rx_data, 8'h11);
    m_bits8(8'h33); m_ack(ak);
    check("R13 after NACK ignored", ak, 0);
    m_stop();
    pulse_clr();
    check("R4 ovf sticky", ovf, 1);
  endtask

  task automatic t_override();
    override_en = 1;
    m_start();
    m_bits8({OWN, 1'b0}); m_ack(ak);
    check("R5 addr ACK while full", ak, 1);
    check("R5 addr loaded", rx_data, {OWN, 1'b0});
    m_bits8(8'h44); m_ack(ak);
    check("R5 data ACK while full", ak, 1);
    check("R5 data loaded", rx_data, 8'h44);
    m_stop();
    override_en = 0;
    pulse_ovc(); pulse_rd(); pulse_clr();
    check("R4 ovf_clr", ovf, 0);
  endtask

  task automatic t_stretch();
    stretch_en = 1;
    m_start();
    m_bits8({OWN, 1'b0}); m_ack(ak);
    check("R7 addr ACK", ak, 1);
    check("R7 scl held", scl_oe, 1);
    check("R7 rel cleared", rel, 0);
    check("R7 line low", scl_bus, 0);
    pulse_rd(); pulse_clr();
    pulse_rel();
    check("R7 scl released", scl_oe, 0);
    check("R7 rel set", rel, 1);
    m_bits8(8'h55); m_ack(ak);
    check("R7 data ACK", ak, 1);
    check("R7 data stretch", scl_oe, 1);
    pulse_rd(); pulse_clr(); pulse_rel();
    m_stop();
    stretch_en = 0;
  endtask

  task automatic t_hold();
    addr_hold_en = 1; data_hold_en = 1;
    m_start();
    m_bits8({OWN, 1'b0});
    check("R8 irq at 8th", irq, 1);
    check("R9 ack_time hold", ack_time, 1);
    check("R8 rel cleared", rel, 0);
    check("R8 scl held", scl_oe, 1);
    check("R8 sda free in hold", sda_oe, 0);
    pulse_clr(); pulse_rd();
    ack_nack = 0;
    pulse_rel();
    m_ack(ak);
    check("R8 host ACK", ak, 1);
    check("R3 irq after held ACK", irq, 1);
    check("R9 ack_time cleared", ack_time, 0);
    pulse_clr();
    m_bits8(8'h66);
    check("R8 data irq", irq, 1);
    check("R8 data loaded", rx_data, 8'h66);
    check("R8 data held", scl_oe, 1);
    pulse_clr(); pulse_rd();
    ack_nack = 1;
    pulse_rel();
    m_ack(ak);
    check("R8 host NACK", ak, 0);
    check("R3 no irq after NACK", irq, 0);
    m_bits8(8'h77); m_ack(ak);
    check("R13 host NACK ends", ak, 0);
    m_stop();
    addr_hold_en = 0; data_hold_en = 0; ack_nack = 0;
  endtask

  task automatic t_events();
    start_irq_en = 1; stop_irq_en = 1;
    m_start();
    check("R10 start irq", irq, 1);
    pulse_clr();
    m_bits8(8'h40); m_ack(ak);
    m_stop();
    check("R10 stop irq", irq, 1);
    check("R10 stop_seen", stop_seen, 1);
    pulse_clr();
    start_irq_en = 0; stop_irq_en = 0;
  endtask

  initial begin
    tick(4);
    rst_n = 1'b1;
    tick(4);
    t_reset();
    t_write();
    t_mismatch();
    t_read();
    t_overflow();
    t_override();
    t_stretch();
    t_hold();
    t_events();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end
endmodule